// File: doc/BRIEF.md
# Vector Integer Element Sequencer

This block runs one integer vector operation over the elements of a vector register file. A one-cycle `start` pulse captures the operation select, the operand source, the scalar value, the element count, the exception enable and the destination register number. The block then presents element indices 0, 1, 2, ... on a read port, one per cycle. It combines the two 64-bit element values it reads back and drives the result on a write port in the same cycle.

Operand A is either the per-element value read on `rdA` or one scalar broadcast to every element. Operand B is always the element read on `rdB`. All arithmetic works on the low 32 bits of each element. When an add, subtract or multiply overflows and exceptions are enabled, a one-cycle report with a cause code and the destination register number goes to an external exception recorder. The run still continues to the last element. A `done` pulse follows the final write.

Top module: `vint_elem_seq`

## Requirements
- R1: After reset, `busy`, `done`, `wrEn` and `excValid` are all low.
- R2: A `start` seen while idle latches every configuration input. Elements 0 to N-1 then follow one per cycle, beginning the cycle after the `start` edge, with `wrEn` high and `wrIdx` equal to `rdIdx`. N is `vecLen` clamped to MAX_LEN. Configuration inputs that change after `start` have no effect on the run.
- R3: `opSel` 0 gives A+B and `opSel` 1 gives A-B. Both use the low 32 bits modulo 2^32, and bits 63:32 of the result are zero.
- R4: `opSel` 2 gives the low 32 bits of the signed 64-bit product A*B, with bits 63:32 of the result zero.
- R5: `opSel` 3 gives A OR B, 4 gives B AND NOT A, and 5 gives A XOR B, each on bits 31:0. Bits 63:32 of the result are copied from the `rdB` element.
- R6: `opSel` 6 shifts B[31:0] left and `opSel` 7 shifts it right, both by A[4:0] positions with zeros filled in. Bits 63:32 of the result are zero.
- R7: With `useScalar` high, the latched `scalarOp` replaces `rdA` as operand A for every element.
- R8: When an add, subtract or multiply element overflows the signed 32-bit range and the enable is set, `excValid` is high in that element's write cycle. `excCode` is 1 for add or subtract and 2 for multiply, and `excDest` holds the latched register number. The low 32 bits of the true result are still written, and the run goes on.
- R9: With the exception enable clear, overflow raises no `excValid`, and the wrapped result is still written.
- R10: `done` is high for the single cycle after the last write, and `busy` is low in that cycle. A length of zero gives `done` the cycle after `start` with no write.
- R11: A `start` pulse while `busy` is high is ignored. The running operation keeps its length and operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| opSel | input | 3 | Operation select (0 add, 1 sub, 2 mul, 3 or, 4 bit clear, 5 xor, 6 shl, 7 shr) |
| useScalar | input | 1 | Take operand A from scalarOp |
| scalarOp | input | LANE_W | Scalar operand A |
| vecLen | input | LEN_W | Number of elements |
| excEnable | input | 1 | Report overflow |
| destReg | input | REG_W | Destination register number for reports |
| rdIdx | output | IDX_W | Element index being read |
| rdA | input | 2*LANE_W | Element of the A register |
| rdB | input | 2*LANE_W | Element of the B register |
| wrEn | output | 1 | Write the result element |
| wrIdx | output | IDX_W | Element index being written |
| wrData | output | 2*LANE_W | Result element |
| excValid | output | 1 | Overflow report strobe |
| excCode | output | 2 | Overflow cause |
| excDest | output | REG_W | Register number reported |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished pulse |

## Verification
Element i is read and written in the (i+1)-th cycle after the clock edge that samples `start`. Its overflow report comes in that same cycle, and `done` comes one cycle after the last element, or one cycle after `start` for a zero length. The bench drives `start` on a falling edge and moves to the next falling edge. From there it compares each element's write, index and report against a value computed with 64-bit integer arithmetic from that element's operands. It steps one falling edge per element and checks `done` at the edge after the loop.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_MUL = 3'd2,
    OP_BIS = 3'd3,
    OP_BIC = 3'd4,
    OP_XOR = 3'd5,
    OP_SLL = 3'd6,
    OP_SRL = 3'd7
  } vop_e;

  typedef struct packed {
    logic load;    // configuration capture on an accepted start
    logic active;  // an element is read and written this cycle
    logic last;    // this element is the final one
  } vseq_strobe_t;

  localparam logic [1:0] EXC_NONE   = 2'd0;
  localparam logic [1:0] EXC_ADDSUB = 2'd1;
  localparam logic [1:0] EXC_MUL    = 2'd2;

endpackage

// File: rtl/vseq_shifter.sv
module vseq_shifter #(
  parameter int W = 32,
  localparam int SH_W = $clog2(W)
) (
  input  logic [W-1:0]    din,
  input  logic [SH_W-1:0] amt,
  input  logic            toLeft,
  output logic [W-1:0]    dout
);

  logic [SH_W:0][W-1:0] stage;

  assign stage[0] = din;

  generate
    for (genvar k = 0; k < SH_W; k++) begin : g_stage
      always_comb begin
        if (!amt[k]) begin
          stage[k+1] = stage[k];
        end else if (toLeft) begin
          stage[k+1] = stage[k] << (1 << k);
        end else begin
          stage[k+1] = stage[k] >> (1 << k);
        end
      end
    end
  endgenerate

  assign dout = stage[SH_W];

endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
  import vseq_pkg::*;
#(
  parameter int MAX_LEN = 64,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int IDX_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] vecLen,
  output vseq_strobe_t     strobe,
  output logic [IDX_W-1:0] idx,
  output logic             busy,
  output logic             done
);

  typedef enum logic {S_IDLE, S_RUN} seqState_e;

  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN);

  seqState_e        state;
  logic [IDX_W-1:0] idxQ;
  logic [LEN_W-1:0] lenQ;
  logic             doneQ;
  logic [LEN_W-1:0] effLen;
  logic             acceptStart;
  logic             running;
  logic             lastElem;

  assign effLen      = (vecLen > LEN_CAP) ? LEN_CAP : vecLen;
  assign running     = (state == S_RUN);
  assign acceptStart = start && !running;
  assign lastElem    = running && ((LEN_W'(idxQ) + LEN_W'(1)) == lenQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      idxQ  <= '0;
      lenQ  <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (acceptStart) begin
        idxQ <= '0;
        lenQ <= effLen;
        if (effLen == '0) begin
          doneQ <= 1'b1;
        end else begin
          state <= S_RUN;
        end
      end else if (running) begin
        if (lastElem) begin
          state <= S_IDLE;
          doneQ <= 1'b1;
        end else begin
          idxQ <= idxQ + IDX_W'(1);
        end
      end
    end
  end

  assign strobe.load   = acceptStart;
  assign strobe.active = running;
  assign strobe.last   = lastElem;
  assign idx           = idxQ;
  assign busy          = running;
  assign done          = doneQ;

  // R2: indices advance by one each cycle until the last element
  p_idx_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.active && !strobe.last |=> strobe.active && (idx == $past(idx) + IDX_W'(1)));

  // R10: the cycle after the last element carries done with busy low
  p_done_after_last_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.last |=> done && !busy);

  // R10: zero length finishes immediately
  p_zero_len_r10: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy && (vecLen == '0) |=> done && !busy);

  // R11: start during a run leaves the length alone
  p_ignore_start_r11: assert property (@(posedge clk) disable iff (!rstN)
    start && busy && !strobe.last |=> busy && $stable(lenQ));

endmodule

// File: rtl/vseq_datapath.sv
module vseq_datapath
  import vseq_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int REG_W  = 4,
  localparam int ELEM_W = 2 * LANE_W,
  localparam int SH_W   = $clog2(LANE_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  vseq_strobe_t      strobe,
  input  logic [2:0]        opSel,
  input  logic              useScalar,
  input  logic [LANE_W-1:0] scalarOp,
  input  logic              excEnable,
  input  logic [REG_W-1:0]  destReg,
  input  logic [ELEM_W-1:0] rdA,
  input  logic [ELEM_W-1:0] rdB,
  output logic              wrEn,
  output logic [ELEM_W-1:0] wrData,
  output logic              excValid,
  output logic [1:0]        excCode,
  output logic [REG_W-1:0]  excDest
);

  // captured configuration
  vop_e              opQ;
  logic              useScQ;
  logic [LANE_W-1:0] scalarQ;
  logic              excEnQ;
  logic [REG_W-1:0]  destQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ     <= OP_ADD;
      useScQ  <= 1'b0;
      scalarQ <= '0;
      excEnQ  <= 1'b0;
      destQ   <= '0;
    end else if (strobe.load) begin
      opQ     <= vop_e'(opSel);
      useScQ  <= useScalar;
      scalarQ <= scalarOp;
      excEnQ  <= excEnable;
      destQ   <= destReg;
    end
  end

  // operand lanes
  logic [LANE_W-1:0] laneA;
  logic [LANE_W-1:0] laneB;
  logic [LANE_W-1:0] upperB;
  logic              unusedUpperA;

  assign laneA        = useScQ ? scalarQ : rdA[LANE_W-1:0];
  assign laneB        = rdB[LANE_W-1:0];
  assign upperB       = rdB[ELEM_W-1:LANE_W];
  assign unusedUpperA = ^rdA[ELEM_W-1:LANE_W];

  // adder / subtractor sharing one carry chain
  logic              isSub;
  logic [LANE_W-1:0] addB;
  logic [LANE_W-1:0] sumLane;
  logic              sumOvf;

  assign isSub   = (opQ == OP_SUB);
  assign addB    = isSub ? ~laneB : laneB;
  assign sumLane = laneA + addB + LANE_W'(isSub);
  assign sumOvf  = (laneA[LANE_W-1] == addB[LANE_W-1]) &&
                   (sumLane[LANE_W-1] != laneA[LANE_W-1]);

  // signed multiplier
  logic signed [ELEM_W-1:0] prodFull;
  logic [LANE_W:0]          prodHigh;
  logic                     mulOvf;

  assign prodFull = $signed(laneA) * $signed(laneB);
  assign prodHigh = prodFull[ELEM_W-1:LANE_W-1];
  assign mulOvf   = !((&prodHigh) || (~|prodHigh));

  // logical shifter
  logic [LANE_W-1:0] shiftLane;

  vseq_shifter #(.W(LANE_W)) u_shift (
    .din    (laneB),
    .amt    (laneA[SH_W-1:0]),
    .toLeft (opQ == OP_SLL),
    .dout   (shiftLane)
  );

  // result select
  logic [ELEM_W-1:0] result;
  logic              laneOvf;
  logic [1:0]        laneCode;

  always_comb begin
    result   = '0;
    laneOvf  = 1'b0;
    laneCode = EXC_NONE;
    unique case (opQ)
      OP_ADD, OP_SUB: begin
        result[LANE_W-1:0] = sumLane;
        laneOvf            = sumOvf;
        laneCode           = EXC_ADDSUB;
      end
      OP_MUL: begin
        result[LANE_W-1:0] = prodFull[LANE_W-1:0];
        laneOvf            = mulOvf;
        laneCode           = EXC_MUL;
      end
      OP_BIS: result = {upperB, laneA | laneB};
      OP_BIC: result = {upperB, laneB & ~laneA};
      OP_XOR: result = {upperB, laneA ^ laneB};
      OP_SLL, OP_SRL: result[LANE_W-1:0] = shiftLane;
      default: result = '0;
    endcase
  end

  assign wrEn     = strobe.active;
  assign wrData   = result;
  assign excValid = strobe.active && excEnQ && laneOvf;
  assign excCode  = laneCode;
  assign excDest  = destQ;

  // R8: a report only accompanies an enabled write
  p_exc_with_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> wrEn && excEnQ);

  // R3: arithmetic writes keep the upper half clear
  p_arith_upper_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && (opQ == OP_ADD || opQ == OP_SUB || opQ == OP_MUL) |-> (wrData[ELEM_W-1:LANE_W] == '0));

  // R5: logical writes carry the upper half of B
  p_logic_upper_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && (opQ == OP_BIS || opQ == OP_BIC || opQ == OP_XOR) |-> (wrData[ELEM_W-1:LANE_W] == rdB[ELEM_W-1:LANE_W]));

  // R11: configuration holds while a run continues
  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.active && !strobe.last |=> $stable(opQ) && $stable(scalarQ));

endmodule

// File: rtl/vint_elem_seq.sv
module vint_elem_seq
  import vseq_pkg::*;
#(
  parameter int MAX_LEN = 64,
  parameter int LANE_W  = 32,
  parameter int REG_W   = 4,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int IDX_W  = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1,
  localparam int ELEM_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        opSel,
  input  logic              useScalar,
  input  logic [LANE_W-1:0] scalarOp,
  input  logic [LEN_W-1:0]  vecLen,
  input  logic              excEnable,
  input  logic [REG_W-1:0]  destReg,
  output logic [IDX_W-1:0]  rdIdx,
  input  logic [ELEM_W-1:0] rdA,
  input  logic [ELEM_W-1:0] rdB,
  output logic              wrEn,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [ELEM_W-1:0] wrData,
  output logic              excValid,
  output logic [1:0]        excCode,
  output logic [REG_W-1:0]  excDest,
  output logic              busy,
  output logic              done
);

  vseq_strobe_t     strobe;
  logic [IDX_W-1:0] elemIdx;

  vseq_ctrl #(
    .MAX_LEN (MAX_LEN),
    .LEN_W   (LEN_W),
    .IDX_W   (IDX_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .vecLen (vecLen),
    .strobe (strobe),
    .idx    (elemIdx),
    .busy   (busy),
    .done   (done)
  );

  vseq_datapath #(
    .LANE_W (LANE_W),
    .REG_W  (REG_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .opSel     (opSel),
    .useScalar (useScalar),
    .scalarOp  (scalarOp),
    .excEnable (excEnable),
    .destReg   (destReg),
    .rdA       (rdA),
    .rdB       (rdB),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .excValid  (excValid),
    .excCode   (excCode),
    .excDest   (excDest)
  );

  assign rdIdx = elemIdx;
  assign wrIdx = elemIdx;

endmodule

// File: tb/vint_elem_seq_tb.sv
`timescale 1ns/1ps
module vint_elem_seq_tb;

  localparam int MAXL  = 8;
  localparam int LEN_W = $clog2(MAXL + 1);
  localparam int IDX_W = $clog2(MAXL);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [2:0]        opSel = '0;
  logic              useScalar = 1'b0;
  logic [31:0]       scalarOp = '0;
  logic [LEN_W-1:0]  vecLen = '0;
  logic              excEnable = 1'b0;
  logic [3:0]        destReg = '0;
  logic [IDX_W-1:0]  rdIdx;
  logic [63:0]       rdA;
  logic [63:0]       rdB;
  logic              wrEn;
  logic [IDX_W-1:0]  wrIdx;
  logic [63:0]       wrData;
  logic              excValid;
  logic [1:0]        excCode;
  logic [3:0]        excDest;
  logic              busy;
  logic              done;

  logic [63:0] vA [MAXL];
  logic [63:0] vB [MAXL];

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  assign rdA = vA[rdIdx];
  assign rdB = vB[rdIdx];

  vint_elem_seq #(.MAX_LEN(MAXL), .LANE_W(32), .REG_W(4)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .useScalar(useScalar),
    .scalarOp(scalarOp), .vecLen(vecLen), .excEnable(excEnable), .destReg(destReg),
    .rdIdx(rdIdx), .rdA(rdA), .rdB(rdB), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .excValid(excValid), .excCode(excCode), .excDest(excDest), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input int op, input logic [31:0] a, input logic [63:0] b,
                                output logic [63:0] r, output logic ov, output logic [1:0] code);
    longint sa = longint'(signed'(a));
    longint sb = longint'(signed'(b[31:0]));
    longint t = 0;
    r = '0; ov = 1'b0; code = 2'd0;
    case (op)
      0, 1, 2: begin
        if (op == 0) t = sa + sb;
        else if (op == 1) t = sa - sb;
        else t = sa * sb;
        r[31:0] = t[31:0];
        ov = (t > 64'sd2147483647) || (t < -64'sd2147483648);
        code = (op == 2) ? 2'd2 : 2'd1;
      end
      3: r = {b[63:32], a | b[31:0]};
      4: r = {b[63:32], b[31:0] & ~a};
      5: r = {b[63:32], a ^ b[31:0]};
      6: r[31:0] = b[31:0] << a[4:0];
      default: r[31:0] = b[31:0] >> a[4:0];
    endcase
  endfunction

  task automatic fillData();
    logic [31:0] cornA [6] = '{32'h7fffffff, 32'h80000000, 32'hffffffff, 32'h00000001, 32'h00010000, 32'h80000000};
    logic [31:0] cornB [6] = '{32'h00000001, 32'hffffffff, 32'h80000000, 32'h7fffffff, 32'h00010000, 32'h80000000};
    for (int i = 0; i < MAXL; i++) begin
      vA[i] = {$urandom(), (i < 6) ? cornA[i] : $urandom()};
      vB[i] = {$urandom(), (i < 6) ? cornB[(i + $urandom_range(0, 1)) % 6] : $urandom()};
    end
  endtask

  task automatic runVec(input int op, input bit sc, input logic [31:0] scal, input bit en,
                        input logic [3:0] dst, input int len, input int poke);
    string tagOp [8] = '{"R3", "R3", "R4", "R5", "R5", "R5", "R6", "R6"};
    int eff = (len > MAXL) ? MAXL : len;
    @(negedge clk);
    opSel = 3'(op); useScalar = sc; scalarOp = scal; excEnable = en;
    destReg = dst; vecLen = LEN_W'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2: changes after start must not reach the run
    opSel = 3'(op ^ 5); scalarOp = ~scal; excEnable = !en; destReg = ~dst; useScalar = !sc;
    for (int i = 0; i < eff; i++) begin
      logic [63:0] r;
      logic ov;
      logic [1:0] code;
      logic [31:0] a;
      bit expExc;
      bit ok;
      string tag;
      a = sc ? scal : vA[i][31:0];
      model(op, a, vB[i], r, ov, code);
      expExc = ov && en;
      tag = {"R2 ", tagOp[op], sc ? " R7" : "", ov ? (en ? " R8" : " R9") : "", (poke >= 0) ? " R11" : ""};
      ok = wrEn && busy && (wrIdx == IDX_W'(i)) && (rdIdx == IDX_W'(i)) && (wrData == r) &&
           (excValid == expExc) && (!expExc || (excCode == code && excDest == dst));
      check(ok, tag, {wrData, 29'(wrIdx), wrEn, excValid, excCode},
                     {r, 29'(i), 1'b1, expExc, code});
      if (i == poke) begin
        start = 1'b1; vecLen = LEN_W'(1);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(done && !busy && !wrEn, "R10 done after last write",
          {125'd0, done, busy, wrEn}, {125'd0, 3'b100});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    fillData();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !wrEn && !excValid, "R1 reset state",
          {124'd0, busy, done, wrEn, excValid}, 128'd0);

    for (int op = 0; op < 8; op++) begin
      for (int sc = 0; sc < 2; sc++) begin
        fillData();
        runVec(op, sc[0], (sc != 0) ? ((op >= 6) ? 32'hffffffe3 : 32'h7ffffffe) : 32'h0,
               1'b1, 4'(op + 8 * sc), MAXL, -1);
      end
    end

    fillData();
    runVec(0, 1'b0, 32'h0, 1'b1, 4'd3, 3, -1);           // R2 short length
    runVec(1, 1'b0, 32'h0, 1'b1, 4'd4, 1, -1);           // R2 single element
    runVec(5, 1'b0, 32'h0, 1'b1, 4'd5, 0, -1);           // R10 zero length
    runVec(2, 1'b0, 32'h0, 1'b1, 4'd6, 12, -1);          // R2 length clamp
    runVec(0, 1'b0, 32'h0, 1'b0, 4'd7, MAXL, -1);        // R9 add, disabled
    runVec(2, 1'b0, 32'h0, 1'b0, 4'd8, MAXL, -1);        // R9 mul, disabled
    runVec(1, 1'b1, 32'h80000000, 1'b1, 4'd9, MAXL, -1); // R8 scalar sub
    runVec(7, 1'b0, 32'h0, 1'b1, 4'd10, MAXL, 2);        // R11 start while busy
    runVec(0, 1'b0, 32'h0, 1'b1, 4'd11, MAXL, 0);        // R11 start in first element
    runVec(4, 1'b1, 32'h0f0f0f0f, 1'b1, 4'd12, 5, -1);   // R5 R7 bit clear

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule